// File: doc/BRIEF.md
# Virtual-Function Device-Memory Translation Walker

This block turns a device-memory offset issued on behalf of a virtual function into the matching offset in the physical function's memory. It does this by walking a translation table held in memory. The walker reads one table entry at a time through a simple read master. The first table is a root directory with one slot per function number, indexed by that number and not by address. Each root slot leads to a table that belongs to that function, and the final level maps 2 MB pages.

A parameter selects one of two table shapes. The short shape has a root directory followed by a leaf table, and all its entries are 32 bits wide. The deep shape has a root directory, then a mid-level directory, then a leaf table. In the deep shape the two directory levels use 64-bit entries and the leaf uses 32-bit entries.

A control word gives the enable flag and the root base. Only one translation is in flight at a time. A response is held until the consumer takes it. A bad request, or an entry whose valid flag is clear, ends the walk with a fault code that names where the walk stopped.

Top module: `vf_lmem_xlate`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1, while `rsp_valid` and `mem_req` are 0.
- R2: When `cfg_ctl[31]` (enable) is 0 at acceptance, the request ends with `rsp_fault`=1, `rsp_code`=0 and `rsp_off`=0, and no table read is issued.
- R3: A function id of 0 or of 64 and above gets the same code-0 fault with no table read.
- R4: The root read goes to `cfg_ctl[30:0]`×64 KB + fid×E. E is 4 bytes in the short shape and 8 bytes in the deep shape. Every table read address is 4-byte aligned.
- R5: A directory entry is valid when bit 0 is 1. Its next-table base is bits [HAW-13:4]×64 KB. Bits 3:1 and all bits above HAW-13 are ignored. HAW is 37 for the short shape and 48 for the deep shape.
- R6: In the short shape, the leaf read goes to base + offset[HAW-1:21]×4. Offset bits at and above HAW do not change the result.
- R7: In the deep shape, the mid-level read goes to base + offset[47:35]×8 and the leaf read goes to base + offset[34:21]×4.
- R8: A valid leaf entry (bit 0 = 1) with page field [HAW-17:5] gives `rsp_fault`=0, `rsp_code`=0 and `rsp_off` = page×2 MB + offset[20:0]. Leaf bits 4:1 and the bits above the field are ignored.
- R9: An entry with bit 0 clear (all zeros included) ends the walk at once. The result is `rsp_fault`=1 and `rsp_off`=0, with `rsp_code` set to 1 for the root, 2 for the mid level and 3 for the leaf.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds steady, `req_ready` stays 0, and no new request is taken.
- R11: `mem_wide` is 1 for directory reads in the deep shape. It is 0 for leaf reads and for every read in the short shape, where only `mem_rdata[31:0]` is used.
- R12: At most one table read is outstanding. `mem_req` is a single-cycle pulse, and it is not raised again until `mem_rvalid` has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctl | input | 32 | Bit 31 enable, bits 30:0 root base in 64 KB units |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| req_fid | input | FID_W | Virtual function number |
| req_off | input | 48 | Offset issued by the function |
| mem_req | output | 1 | Table read strobe (one cycle) |
| mem_addr | output | 48 | Byte address of the table entry |
| mem_wide | output | 1 | 1 = 64-bit entry, 0 = 32-bit entry |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Entry value, low-justified |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Translation failed |
| rsp_code | output | 2 | 0 request rejected or success, 1 root, 2 mid, 3 leaf |
| rsp_off | output | 48 | Translated offset, 0 on a fault |

## Verification
The hardest situation to reach from the ports is a failed entry one or two levels down the walk. It needs a valid root slot that points to a table whose mid-level or leaf entry has its valid flag clear. The bench reaches it with a sparse memory model. That model holds a valid chain only up to the chosen level and returns zero or a cleared flag beyond it, in both table shapes. Reserved bits are set in every valid entry, and high offset bits are set, so that a decoder which leaks them changes the address or the result.

// File: rtl/vfw_pkg.sv
package vfw_pkg;
  localparam int ADDR_W     = 48;  // widest host address width of either shape
  localparam int PTR_SHIFT  = 16;  // directory pointers count 64 KB blocks
  localparam int PAGE_SHIFT = 21;  // leaf pages are 2 MB
  localparam int NUM_FN     = 64;  // root directory slots

  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_ROOT = 2'd1,
    LV_MID  = 2'd2,
    LV_LEAF = 2'd3
  } walk_lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } walk_st_e;

  // entry byte address = table base + index scaled by entry size
  function automatic logic [63:0] tbl_addr(input logic [63:0] base,
                                           input logic [63:0] idx,
                                           input int unsigned esz_log2);
    return base + (idx << esz_log2);
  endfunction
endpackage

// File: rtl/vfw_entry_decode.sv
module vfw_entry_decode #(
  parameter int HAW = 37
) (
  input  logic [63:0]               raw,
  output logic                      ent_valid,
  output logic [vfw_pkg::ADDR_W-1:0] next_base,
  output logic [vfw_pkg::ADDR_W-1:0] page_base
);
  import vfw_pkg::*;
  localparam int DIR_HI  = HAW - 13;
  localparam int PAGE_HI = HAW - 17;

  logic unused_rsvd;

  assign ent_valid = raw[0];
  assign next_base = ADDR_W'({raw[DIR_HI:4], {PTR_SHIFT{1'b0}}});
  assign page_base = ADDR_W'({raw[PAGE_HI:5], {PAGE_SHIFT{1'b0}}});
  assign unused_rsvd = ^{raw[63:DIR_HI+1], raw[3:1]};
endmodule

// File: rtl/vfw_index_gen.sv
module vfw_index_gen #(
  parameter bit THREE_LEVEL = 1'b0,
  parameter int HAW         = 37
) (
  input  vfw_pkg::walk_lvl_e         lvl,
  input  logic [5:0]                 fn,
  input  logic [vfw_pkg::ADDR_W-1:0] off,
  input  logic [vfw_pkg::ADDR_W-1:0] base,
  output logic [vfw_pkg::ADDR_W-1:0] addr,
  output logic                       wide
);
  import vfw_pkg::*;
  logic unused_off;

  if (THREE_LEVEL) begin : g_deep
    always_comb begin
      case (lvl)
        LV_ROOT: begin
          addr = ADDR_W'(tbl_addr(64'(base), 64'(fn), 3));
          wide = 1'b1;
        end
        LV_MID: begin
          addr = ADDR_W'(tbl_addr(64'(base), 64'(off[47:35]), 3));
          wide = 1'b1;
        end
        default: begin
          addr = ADDR_W'(tbl_addr(64'(base), 64'(off[34:21]), 2));
          wide = 1'b0;
        end
      endcase
    end
    assign unused_off = ^off[20:0];
  end else begin : g_short
    always_comb begin
      if (lvl == LV_ROOT)
        addr = ADDR_W'(tbl_addr(64'(base), 64'(fn), 2));
      else
        addr = ADDR_W'(tbl_addr(64'(base), 64'(off[HAW-1:21]), 2));
      wide = 1'b0;
    end
    assign unused_off = ^{off[ADDR_W-1:HAW], off[20:0]};
  end
endmodule

// File: rtl/vf_lmem_xlate.sv
module vf_lmem_xlate #(
  parameter bit THREE_LEVEL = 1'b0,
  parameter int HAW_2L      = 37,
  parameter int FID_W       = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [31:0]                cfg_ctl,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [FID_W-1:0]           req_fid,
  input  logic [vfw_pkg::ADDR_W-1:0] req_off,
  output logic                       mem_req,
  output logic [vfw_pkg::ADDR_W-1:0] mem_addr,
  output logic                       mem_wide,
  input  logic                       mem_rvalid,
  input  logic [63:0]                mem_rdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_fault,
  output logic [1:0]                 rsp_code,
  output logic [vfw_pkg::ADDR_W-1:0] rsp_off
);
  import vfw_pkg::*;
  localparam int HAW = THREE_LEVEL ? 48 : HAW_2L;

  walk_st_e          st;
  walk_lvl_e         lvl;
  logic [5:0]        fn_q;
  logic [ADDR_W-1:0] off_q, base_q, res_q;
  logic              fault_q;
  logic [1:0]        code_q;

  // named events for the checker
  logic              acc_fire, fn_ok, pre_reject, entry_fault, walk_done;
  logic [63:0]       ent_raw;
  logic              dec_valid;
  logic [ADDR_W-1:0] dec_next, dec_page;

  assign acc_fire    = (st == ST_IDLE) && req_valid;
  assign fn_ok       = (req_fid != '0) && (req_fid < FID_W'(NUM_FN));
  assign pre_reject  = acc_fire && !(cfg_ctl[31] && fn_ok);
  assign ent_raw     = mem_wide ? mem_rdata : {32'h0, mem_rdata[31:0]};
  assign entry_fault = (st == ST_WAIT) && mem_rvalid && !dec_valid;
  assign walk_done   = (st == ST_WAIT) && mem_rvalid && dec_valid && (lvl == LV_LEAF);

  vfw_entry_decode #(.HAW(HAW)) u_dec (
    .raw       (ent_raw),
    .ent_valid (dec_valid),
    .next_base (dec_next),
    .page_base (dec_page)
  );

  vfw_index_gen #(.THREE_LEVEL(THREE_LEVEL), .HAW(HAW)) u_idx (
    .lvl  (lvl),
    .fn   (fn_q),
    .off  (off_q),
    .base (base_q),
    .addr (mem_addr),
    .wide (mem_wide)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lvl     <= LV_NONE;
      fn_q    <= '0;
      off_q   <= '0;
      base_q  <= '0;
      res_q   <= '0;
      fault_q <= 1'b0;
      code_q  <= 2'd0;
    end else begin
      case (st)
        ST_IDLE: if (acc_fire) begin
          fn_q  <= req_fid[5:0];
          off_q <= req_off;
          if (pre_reject) begin
            fault_q <= 1'b1;
            code_q  <= 2'd0;
            res_q   <= '0;
            st      <= ST_RESP;
          end else begin
            base_q <= ADDR_W'({cfg_ctl[30:0], {PTR_SHIFT{1'b0}}});
            lvl    <= LV_ROOT;
            st     <= ST_ISSUE;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) begin
          if (!dec_valid) begin
            fault_q <= 1'b1;
            code_q  <= lvl;
            res_q   <= '0;
            st      <= ST_RESP;
          end else if (lvl == LV_LEAF) begin
            fault_q <= 1'b0;
            code_q  <= 2'd0;
            res_q   <= dec_page | ADDR_W'(off_q[PAGE_SHIFT-1:0]);
            st      <= ST_RESP;
          end else begin
            base_q <= dec_next;
            lvl    <= (THREE_LEVEL && lvl == LV_ROOT) ? LV_MID : LV_LEAF;
            st     <= ST_ISSUE;
          end
        end
        default: if (rsp_ready) begin
          st  <= ST_IDLE;
          lvl <= LV_NONE;
        end
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_ISSUE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_fault = fault_q;
  assign rsp_code  = code_q;
  assign rsp_off   = res_q;
endmodule

// File: rtl/vf_lmem_xlate_chk.sv
module vf_lmem_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req,
  input logic [47:0] mem_addr,
  input logic        mem_wide,
  input logic        mem_rvalid,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic [1:0]  rsp_code,
  input logic [47:0] rsp_off,
  input logic        pre_reject,
  input logic        entry_fault,
  input logic        walk_done,
  input logic [1:0]  lvl_i
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> req_ready && !rsp_valid && !mem_req); // R1

  AST_REJECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pre_reject |=> !mem_req && rsp_valid && rsp_fault && rsp_code == 2'd0 && rsp_off == '0); // R2 R3

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00 && (!mem_wide || mem_addr[2] == 1'b0)); // R4

  AST_SUCCESS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> rsp_valid && !rsp_fault && rsp_code == 2'd0); // R8

  AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fault |=> rsp_valid && rsp_fault && rsp_code == $past(lvl_i) && rsp_off == '0); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_off) && $stable(rsp_code) && $stable(rsp_fault)); // R10

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10

  AST_LEAF_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && lvl_i == 2'd3 |-> !mem_wide); // R11

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R12

  AST_NO_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_rvalid); // R12
endmodule

bind vf_lmem_xlate vf_lmem_xlate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_wide    (mem_wide),
  .mem_rvalid  (mem_rvalid),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_fault   (rsp_fault),
  .rsp_code    (rsp_code),
  .rsp_off     (rsp_off),
  .pre_reject  (pre_reject),
  .entry_fault (entry_fault),
  .walk_done   (walk_done),
  .lvl_i       (lvl)
);

// File: tb/vf_lmem_xlate_test.sv
`timescale 1ns/1ps
module vf_lmem_xlate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // index 0: short shape (uut), index 1: deep shape (uut_ml)
  logic [31:0] cfg   [2];
  logic        rq_v  [2];
  logic        rq_r  [2];
  logic [7:0]  rq_fid[2];
  logic [47:0] rq_off[2];
  logic        mreq  [2];
  logic [47:0] maddr [2];
  logic        mwide [2];
  logic        mrv   [2];
  logic [63:0] mrd   [2];
  logic        rv    [2];
  logic        rr    [2];
  logic        rf    [2];
  logic [1:0]  rc    [2];
  logic [47:0] ro    [2];

  vf_lmem_xlate #(.THREE_LEVEL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_ctl(cfg[0]),
    .req_valid(rq_v[0]), .req_ready(rq_r[0]), .req_fid(rq_fid[0]), .req_off(rq_off[0]),
    .mem_req(mreq[0]), .mem_addr(maddr[0]), .mem_wide(mwide[0]),
    .mem_rvalid(mrv[0]), .mem_rdata(mrd[0]),
    .rsp_valid(rv[0]), .rsp_ready(rr[0]), .rsp_fault(rf[0]), .rsp_code(rc[0]), .rsp_off(ro[0]));

  vf_lmem_xlate #(.THREE_LEVEL(1'b1)) uut_ml (
    .clk(clk), .rst_n(rst_n), .cfg_ctl(cfg[1]),
    .req_valid(rq_v[1]), .req_ready(rq_r[1]), .req_fid(rq_fid[1]), .req_off(rq_off[1]),
    .mem_req(mreq[1]), .mem_addr(maddr[1]), .mem_wide(mwide[1]),
    .mem_rvalid(mrv[1]), .mem_rdata(mrd[1]),
    .rsp_valid(rv[1]), .rsp_ready(rr[1]), .rsp_fault(rf[1]), .rsp_code(rc[1]), .rsp_off(ro[1]));

  // sparse table memory, two-cycle read latency
  logic [63:0] mm [longint];
  logic        pend [2];
  int          dly  [2];
  logic [47:0] paddr[2];
  logic [47:0] alog [2][16];
  logic        wlog [2][16];
  int          rcnt [2] = '{0, 0};

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      mrv[k] <= 1'b0;
      if (!rst_n) pend[k] <= 1'b0;
      else if (mreq[k]) begin
        pend[k]  <= 1'b1;
        dly[k]   <= 1;
        paddr[k] <= maddr[k];
        alog[k][rcnt[k] % 16] <= maddr[k];
        wlog[k][rcnt[k] % 16] <= mwide[k];
        rcnt[k] <= rcnt[k] + 1;
      end else if (pend[k]) begin
        if (dly[k] == 0) begin
          mrv[k]  <= 1'b1;
          mrd[k]  <= mm.exists(longint'(paddr[k])) ? mm[longint'(paddr[k])] : 64'h0;
          pend[k] <= 1'b0;
        end else dly[k] <= dly[k] - 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one translation; hold = cycles to keep rsp_ready low while poking req_valid
  task automatic run(input int k, input logic [7:0] fid, input logic [47:0] off, input int hold,
                     output logic f, output logic [1:0] c, output logic [47:0] o,
                     output int nrd, output int r0);
    r0 = rcnt[k];
    @(negedge clk);
    rq_fid[k] = fid; rq_off[k] = off; rq_v[k] = 1'b1;
    @(negedge clk);
    rq_v[k] = 1'b0;
    while (!rv[k]) @(negedge clk);
    f = rf[k]; c = rc[k]; o = ro[k];
    for (int i = 0; i < hold; i++) begin
      rq_v[k] = 1'b1; rq_fid[k] = 8'd5;
      @(negedge clk);
      chk("R10", "rsp_valid held", longint'(rv[k]), 1);
      chk("R10", "req_ready low while busy", longint'(rq_r[k]), 0);
      chk("R10", "rsp_off stable", longint'(ro[k]), longint'(o));
      chk("R10", "no new walk", rcnt[k] - r0, 2);
    end
    rq_v[k] = 1'b0; rr[k] = 1'b1;
    @(negedge clk);
    rr[k] = 1'b0;
    nrd = rcnt[k] - r0;
  endtask

  function automatic longint la(input int k, input int r0, input int j);
    return longint'(alog[k][(r0 + j) % 16]);
  endfunction

  task automatic t_reset();
    for (int k = 0; k < 2; k++) begin
      chk("R1", "req_ready after reset", longint'(rq_r[k]), 1);
      chk("R1", "rsp_valid after reset", longint'(rv[k]), 0);
      chk("R1", "mem_req after reset", longint'(mreq[k]), 0);
    end
  endtask

  task automatic t_short_ok();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    run(0, 8'd5, 48'h61ABCD, 0, f, c, o, n, r0);
    chk("R8", "fault flag", longint'(f), 0);
    chk("R8", "code", longint'(c), 0);
    chk("R8", "translated offset", longint'(o), 64'h2461ABCD);
    chk("R4", "read count", n, 2);
    chk("R4", "root address fid5", la(0, r0, 0), 64'h100014);
    chk("R5", "leaf table base from pointer", la(0, r0, 1), 64'h20000C);
    chk("R11", "short root narrow", longint'(wlog[0][r0 % 16]), 0);
    chk("R11", "short leaf narrow", longint'(wlog[0][(r0 + 1) % 16]), 0);
  endtask

  task automatic t_short_upper_ignored();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    run(0, 8'd5, 48'h0120_0061_ABCD, 0, f, c, o, n, r0);
    chk("R6", "offset above HAW ignored", longint'(o), 64'h2461ABCD);
    chk("R6", "leaf address unchanged", la(0, r0, 1), 64'h20000C);
  endtask

  task automatic t_short_corner();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    run(0, 8'd63, 48'h1F_FFFF_FFFF, 0, f, c, o, n, r0);
    chk("R4", "root address fid63", la(0, r0, 0), 64'h1000FC);
    chk("R6", "last leaf slot address", la(0, r0, 1), 64'h33FFFC);
    chk("R8", "largest page", longint'(o), 64'h1F_FFFF_FFFF);
  endtask

  task automatic t_bad_fid();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    logic [7:0] bad [3] = '{8'd0, 8'd64, 8'd200};
    foreach (bad[i]) begin
      run(0, bad[i], 48'h61ABCD, 0, f, c, o, n, r0);
      chk("R3", "bad fid faults", longint'(f), 1);
      chk("R3", "bad fid code", longint'(c), 0);
      chk("R3", "bad fid no reads", n, 0);
    end
  endtask

  task automatic t_disabled();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    cfg[0] = 32'h0000_0010;
    run(0, 8'd5, 48'h61ABCD, 0, f, c, o, n, r0);
    chk("R2", "disabled faults", longint'(f), 1);
    chk("R2", "disabled code", longint'(c), 0);
    chk("R2", "disabled offset zero", longint'(o), 0);
    chk("R2", "disabled no reads", n, 0);
    cfg[0] = 32'h8000_0010;
  endtask

  task automatic t_root_invalid();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    run(0, 8'd7, 48'h61ABCD, 0, f, c, o, n, r0);
    chk("R9", "zero root entry code", longint'(c), 1);
    chk("R9", "zero root entry reads", n, 1);
    run(0, 8'd8, 48'h61ABCD, 0, f, c, o, n, r0);
    chk("R9", "cleared-flag root fault", longint'(f), 1);
    chk("R9", "cleared-flag root code", longint'(c), 1);
    chk("R9", "fault offset zero", longint'(o), 0);
  endtask

  task automatic t_leaf_invalid();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    run(0, 8'd9, 48'h21_2345, 0, f, c, o, n, r0);
    chk("R9", "leaf fault flag", longint'(f), 1);
    chk("R9", "leaf fault code", longint'(c), 3);
    chk("R9", "leaf fault reads", n, 2);
    chk("R9", "leaf address", la(0, r0, 1), 64'h400004);
  endtask

  task automatic t_hold();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    run(0, 8'd5, 48'h61ABCD, 5, f, c, o, n, r0);
    chk("R10", "held response value", longint'(o), 64'h2461ABCD);
    chk("R10", "idle after release", longint'(rq_r[0]), 1);
    chk("R12", "reads in held walk", n, 2);
  endtask

  task automatic t_deep_ok();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    run(1, 8'd2, 48'h0028_0040_0ABC, 0, f, c, o, n, r0);
    chk("R8", "deep translated offset", longint'(o), 64'h8000_0020_0ABC);
    chk("R8", "deep fault flag", longint'(f), 0);
    chk("R7", "deep read count", n, 3);
    chk("R4", "deep root address", la(1, r0, 0), 64'h800010);
    chk("R7", "mid address", la(1, r0, 1), 64'h900028);
    chk("R7", "leaf address", la(1, r0, 2), 64'hA00008);
    chk("R11", "deep root wide", longint'(wlog[1][r0 % 16]), 1);
    chk("R11", "deep mid wide", longint'(wlog[1][(r0 + 1) % 16]), 1);
    chk("R11", "deep leaf narrow", longint'(wlog[1][(r0 + 2) % 16]), 0);
  endtask

  task automatic t_deep_mid_invalid();
    logic f; logic [1:0] c; logic [47:0] o; int n, r0;
    run(1, 8'd3, 48'h0028_0040_0ABC, 0, f, c, o, n, r0);
    chk("R9", "mid fault code", longint'(c), 2);
    chk("R9", "mid fault reads", n, 2);
    chk("R7", "mid address from root ptr", la(1, r0, 1), 64'hB00028);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      rq_v[k] = 1'b0; rq_fid[k] = '0; rq_off[k] = '0; rr[k] = 1'b0;
    end
    cfg[0] = 32'h8000_0010;
    cfg[1] = 32'h8000_0080;
    // short shape tables (reserved bits set in valid entries)
    mm[64'h100014] = 64'h0000_0000_FE00_020F;
    mm[64'h20000C] = 64'h0000_0000_FFE0_247F;
    mm[64'h1000FC] = 64'h0000_0000_0000_0301;
    mm[64'h33FFFC] = 64'h0000_0000_001F_FFE1;
    mm[64'h100020] = 64'h0000_0000_0000_0FF0;
    mm[64'h100024] = 64'h0000_0000_0000_0401;
    mm[64'h400004] = 64'h0000_0000_0000_2460;
    // deep shape tables
    mm[64'h800010] = 64'hF000_0000_0000_0901;
    mm[64'h900028] = 64'hFFFF_FFF0_0000_0A0F;
    mm[64'hA00008] = 64'h0000_0000_8000_0021;
    mm[64'h800018] = 64'h0000_0000_0000_0B01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_ok();
    t_short_upper_ignored();
    t_short_corner();
    t_bad_fid();
    t_disabled();
    t_root_invalid();
    t_leaf_invalid();
    t_hold();
    t_deep_ok();
    t_deep_mid_invalid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule